// File: doc/BRIEF.md
# Two-Wire Block-Write Configuration Slave

This block is a small serial slave that holds the six configuration bytes of a clock generator. A host on a two-wire bus (SCL, SDA) loads the bytes with one block write and can fetch them back with one block read. Both bus lines are oversampled on a fast system clock. The block never drives SDA high. It only asserts an output enable that pulls the wire low, and an external pull-up does the rest.

A write frame starts with the write address, then a command byte and a count byte. Both of those are acknowledged and then thrown away. The data bytes follow. They always land starting at byte 0, one after another, and a stop is allowed after any complete byte. A read frame starts with the read address. The slave answers with a byte count, then sends the stored bytes in order until the master answers with a NACK. All six bytes are visible in parallel to the rest of the chip at all times.

Top module: `cfg_serial_slave`

## Requirements
- R1: The 8-bit address 0xD2 (write) and 0xD3 (read) are acknowledged by pulling SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores the bus until the next start.
- R2: In a write frame, the two bytes after the address are acknowledged. Their values have no effect on any stored byte.
- R3: Write data bytes are stored in arrival order into byte 0, byte 1, up to byte 5. Each one is acknowledged. A stored byte appears on `cfg_bytes_o[8k+7:8k]` for byte k.
- R4: A stop after any complete data byte keeps the bytes already stored. The bytes not reached keep their previous values.
- R5: Data bytes beyond byte 5 are acknowledged and discarded.
- R6: A read frame returns the byte count 6 first, then bytes 0 to 5. Each byte is sent most significant bit first.
- R7: When the master answers a read byte with NACK, the slave releases SDA and sends nothing more. Further clocks read as all ones.
- R8: After reset the bytes are: byte 0 = 0x1F, byte 1 = 0xFF, byte 2 = 0xFE, bytes 3, 4 and 5 = 0x00.
- R9: A start or stop seen in the middle of a byte aborts the frame. The partial byte is not stored, and a new write begins again at byte 0.
- R10: SDA is only ever pulled low. The pull-down only changes while SCL is low, and it is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| cfg_bytes_o | output | 48 | All configuration bytes, byte k in bits 8k+7:8k |

## Verification
Several rules are checked on every cycle:
- the pull-down only asserts while the synchronized SCL is low;
- a stop always frees the line;
- a start always restarts the frame;
- an unknown address drops the slave to idle without an acknowledge;
- writes never reach a byte index outside the register file;
- the defaults are present right after reset.

Other behaviours only show in the bench's frames: the exact byte order, that the discarded command and count bytes leave the registers unchanged, that partial frames keep earlier bytes, the count-then-data read sequence, and that the line stays released after a NACK.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;

    localparam int CFG_NUM_BYTES = 6;
    localparam logic [6:0] CFG_DEV_ADDR7 = 7'h69;
    localparam logic [CFG_NUM_BYTES*8-1:0] CFG_DEFAULTS = 48'h00_00_00_FE_FF_1F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } fr_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] a);
        return b[7:1] == a;
    endfunction

endpackage

// File: rtl/cfgser_line_sync.sv
module cfgser_line_sync
    import cfgser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic scl_q;
    logic sda_q;
    logic scl_s;
    logic sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/cfgser_reg_bank.sv
module cfgser_reg_bank
    import cfgser_pkg::*;
#(
    parameter int NUM_BYTES = CFG_NUM_BYTES,
    parameter logic [NUM_BYTES*8-1:0] DEFAULTS = CFG_DEFAULTS,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       widx_i,
    input  logic [7:0]             wdata_i,
    input  logic [IDX_W-1:0]       ridx_i,
    output logic [7:0]             rdata_o,
    output logic [NUM_BYTES*8-1:0] bytes_o
);

    logic [7:0] regs [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= DEFAULTS[g*8 +: 8];
            end else if (we_i && widx_i == IDX_W'(g)) begin
                regs[g] <= wdata_i;
            end
        end
        assign bytes_o[g*8 +: 8] = regs[g];
    end

    always_comb begin
        rdata_o = 8'hFF;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (ridx_i == IDX_W'(k)) begin
                rdata_o = regs[k];
            end
        end
    end

    // R8: defaults present on the first cycle after reset
    assert_defaults_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bytes_o == DEFAULTS));

    // R5: a write strobe never targets a byte outside the file
    assert_widx_range_R5: assert property (@(posedge clk) disable iff (rst)
        we_i |-> (widx_i < IDX_W'(NUM_BYTES)));

endmodule

// File: rtl/cfgser_frame_ctrl.sv
module cfgser_frame_ctrl
    import cfgser_pkg::*;
#(
    parameter int NUM_BYTES = CFG_NUM_BYTES,
    parameter logic [6:0] DEV_ADDR7 = CFG_DEV_ADDR7,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  line_ev_t         ev_i,
    input  logic [7:0]       rdata_i,
    output logic             sda_oe_o,
    output logic             we_o,
    output logic [IDX_W-1:0] widx_o,
    output logic [7:0]       wdata_o,
    output logic [IDX_W-1:0] ridx_o
);

    localparam int DATA_BASE = 3;
    localparam logic [IDX_W-1:0] BASE_I = IDX_W'(DATA_BASE);
    localparam logic [IDX_W-1:0] RX_MAX = IDX_W'(DATA_BASE + NUM_BYTES);
    localparam logic [IDX_W-1:0] TX_MAX = IDX_W'(NUM_BYTES);
    localparam logic [7:0] COUNT_BYTE = 8'(NUM_BYTES);

    fr_state_t        state;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_sr;
    logic [7:0]       tx_sr;
    logic [IDX_W-1:0] rx_idx;
    logic [IDX_W-1:0] tx_idx;
    logic             rd_mode;

    assign ridx_o = tx_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            rx_idx   <= '0;
            tx_idx   <= '0;
            rd_mode  <= 1'b0;
            sda_oe_o <= 1'b0;
            we_o     <= 1'b0;
            widx_o   <= '0;
            wdata_o  <= '0;
        end else begin
            we_o <= 1'b0;
            if (ev_i.start) begin
                state    <= ST_RX;
                bit_cnt  <= '0;
                rx_idx   <= '0;
                rd_mode  <= 1'b0;
                sda_oe_o <= 1'b0;
            end else if (ev_i.stop) begin
                state    <= ST_IDLE;
                sda_oe_o <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (ev_i.scl_rise && bit_cnt < 4'd8) begin
                            rx_sr   <= {rx_sr[6:0], ev_i.sda};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev_i.scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (rx_idx == '0) begin
                                if (addr_hit(rx_sr, DEV_ADDR7)) begin
                                    sda_oe_o <= 1'b1;
                                    rd_mode  <= rx_sr[0];
                                    state    <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_oe_o <= 1'b1;
                                state    <= ST_RX_ACK;
                                if (rx_idx >= BASE_I && rx_idx < RX_MAX) begin
                                    we_o    <= 1'b1;
                                    widx_o  <= rx_idx - BASE_I;
                                    wdata_o <= rx_sr;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev_i.scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                state    <= ST_TX;
                                tx_sr    <= COUNT_BYTE;
                                sda_oe_o <= ~COUNT_BYTE[7];
                                tx_idx   <= '0;
                            end else begin
                                sda_oe_o <= 1'b0;
                                state    <= ST_RX;
                                if (rx_idx < RX_MAX) begin
                                    rx_idx <= rx_idx + IDX_W'(1);
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev_i.scl_rise && bit_cnt < 4'd8) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (ev_i.scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe_o <= 1'b0;
                                bit_cnt  <= '0;
                                state    <= ST_TX_ACK;
                            end else if (bit_cnt != 4'd0) begin
                                tx_sr    <= {tx_sr[6:0], 1'b0};
                                sda_oe_o <= ~tx_sr[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev_i.scl_rise && ev_i.sda) begin
                            state <= ST_IDLE;
                        end else if (ev_i.scl_fall) begin
                            tx_sr    <= rdata_i;
                            sda_oe_o <= ~rdata_i[7];
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                            if (tx_idx < TX_MAX) begin
                                tx_idx <= tx_idx + IDX_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the pull-down is only asserted while SCL is low
    assert_pull_while_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !ev_i.scl);

    // R10: a stop frees the line
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        ev_i.stop |=> !sda_oe_o);

    // R9: a start always restarts the frame at the address byte
    assert_start_restart_R9: assert property (@(posedge clk) disable iff (rst)
        ev_i.start |=> (state == ST_RX && bit_cnt == 4'd0 && rx_idx == '0));

    // R1: an unknown address drops to idle with no acknowledge
    assert_addr_gate_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX && rx_idx == '0 && !ev_i.start && !ev_i.stop &&
         ev_i.scl_fall && bit_cnt == 4'd8 && rx_sr[7:1] != DEV_ADDR7)
        |=> (state == ST_IDLE && !sda_oe_o));

    // R7: a NACK from the master ends the read with the line released
    assert_nack_end_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TX_ACK && !ev_i.start && !ev_i.stop && ev_i.scl_rise && ev_i.sda)
        |=> (state == ST_IDLE && !sda_oe_o));

    // R3: one write strobe per received byte
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        we_o |=> !we_o);

endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave
    import cfgser_pkg::*;
#(
    parameter int NUM_BYTES = CFG_NUM_BYTES,
    parameter logic [6:0] DEV_ADDR7 = CFG_DEV_ADDR7,
    parameter logic [NUM_BYTES*8-1:0] DEFAULTS = CFG_DEFAULTS,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe_o,
    output logic [NUM_BYTES*8-1:0] cfg_bytes_o
);

    localparam int IDX_W = $clog2(NUM_BYTES + 4);

    line_ev_t         ev;
    logic             we;
    logic [IDX_W-1:0] widx;
    logic [7:0]       wdata;
    logic [IDX_W-1:0] ridx;
    logic [7:0]       rdata;

    cfgser_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev_o (ev)
    );

    cfgser_frame_ctrl #(
        .NUM_BYTES(NUM_BYTES),
        .DEV_ADDR7(DEV_ADDR7),
        .IDX_W    (IDX_W)
    ) i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ev_i    (ev),
        .rdata_i (rdata),
        .sda_oe_o(sda_oe_o),
        .we_o    (we),
        .widx_o  (widx),
        .wdata_o (wdata),
        .ridx_o  (ridx)
    );

    cfgser_reg_bank #(
        .NUM_BYTES(NUM_BYTES),
        .DEFAULTS (DEFAULTS),
        .IDX_W    (IDX_W)
    ) i_bank (
        .clk    (clk),
        .rst    (rst),
        .we_i   (we),
        .widx_i (widx),
        .wdata_i(wdata),
        .ridx_i (ridx),
        .rdata_o(rdata),
        .bytes_o(cfg_bytes_o)
    );

endmodule

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;

    localparam int Q = 10;
    localparam int NB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [NB*8-1:0] cfg_bytes;

    int checks = 0;
    int errors = 0;
    int hold_viol = 0;
    bit done = 1'b0;
    logic [7:0] exp_b [NB];

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfg_serial_slave i_cfg_serial_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .cfg_bytes_o(cfg_bytes)
    );

    // {cmd, count, number of data bytes, data bytes (byte 0 lowest)}
    localparam logic [67:0] VECS [4] = '{
        {8'h00, 8'h06, 4'd6, 48'h66_55_44_33_22_11},
        {8'hFF, 8'h01, 4'd2, 48'h00_00_00_00_5A_A5},
        {8'h3C, 8'h00, 4'd0, 48'h00_00_00_00_00_00},
        {8'h81, 8'h09, 4'd4, 48'h00_00_C4_C3_C2_C1}
    };

    // R10 monitor: pull-down must not change while SCL has been high
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl_m && prev_scl && sda_oe != prev_oe) hold_viol++;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < NB; k++) begin
            chk(cfg_bytes[k*8 +: 8] == exp_b[k], req, 64'(cfg_bytes[k*8 +: 8]), 64'(exp_b[k]));
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b, output logic seen);
        wait_q();
        sda_m = b;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        seen = sda_line;
        wait_q();
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q();
        sda_m = 1'b0;
        wait_q();
        scl_m = 1'b1;
        wait_q();
        sda_m = 1'b1;
        wait_q();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(b[i], s);
        send_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, s);
            b[i] = s;
        end
        send_bit(~master_ack, s);
    endtask

    task automatic write_frame(input logic [7:0] cmd, input logic [7:0] cnt, input int n,
                               input logic [63:0] data, output logic all_ack);
        logic a;
        all_ack = 1'b1;
        bus_start();
        write_byte(8'hD2, a); all_ack &= a;
        write_byte(cmd, a);   all_ack &= a;
        write_byte(cnt, a);   all_ack &= a;
        for (int k = 0; k < n; k++) begin
            write_byte(data[k*8 +: 8], a);
            all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic a;
        logic [7:0] rb;
        logic s;
        exp_b = '{8'h1F, 8'hFF, 8'hFE, 8'h00, 8'h00, 8'h00};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        // R8 reset defaults
        check_regs("R8 reset default");
        chk(sda_oe == 1'b0, "R10 released after reset", 64'(sda_oe), 64'(0));

        // Table walk: R2 ignored cmd/count, R3 ordered load, R4 partial frames
        for (int v = 0; v < 4; v++) begin
            int n;
            n = int'(VECS[v][51:48]);
            write_frame(VECS[v][67:60], VECS[v][59:52], n, {16'h0, VECS[v][47:0]}, a);
            chk(a == 1'b1, "R1 R2 R3 all bytes acknowledged", 64'(a), 64'(1));
            for (int k = 0; k < n; k++) exp_b[k] = VECS[v][k*8 +: 8];
            check_regs("R3 R4 R2 table frame");
        end

        // R1 unknown address: no ack, following bytes ignored
        bus_start();
        write_byte(8'hA0, a);
        chk(a == 1'b0, "R1 foreign address not acked", 64'(a), 64'(0));
        write_byte(8'h00, a);
        write_byte(8'h00, a);
        write_byte(8'h99, a);
        chk(a == 1'b0, "R1 bytes after foreign address not acked", 64'(a), 64'(0));
        bus_stop();
        check_regs("R1 foreign address leaves bytes");

        // R5 overflow: eight data bytes, last two discarded
        write_frame(8'h00, 8'h08, 8, 64'hEE_DD_06_05_04_03_02_01, a);
        chk(a == 1'b1, "R5 overflow bytes acknowledged", 64'(a), 64'(1));
        for (int k = 0; k < NB; k++) exp_b[k] = 8'(k + 1);
        check_regs("R5 overflow discarded");

        // R6 block read: count 6 then bytes 0..5
        bus_start();
        write_byte(8'hD3, a);
        chk(a == 1'b1, "R1 read address acked", 64'(a), 64'(1));
        read_byte(1'b1, rb);
        chk(rb == 8'd6, "R6 byte count", 64'(rb), 64'(6));
        for (int k = 0; k < NB; k++) begin
            read_byte(k != NB - 1, rb);
            chk(rb == exp_b[k], "R6 read data", 64'(rb), 64'(exp_b[k]));
        end
        bus_stop();

        // R7 NACK ends the read; further clocks read all ones
        bus_start();
        write_byte(8'hD3, a);
        read_byte(1'b1, rb);
        read_byte(1'b0, rb);
        chk(rb == exp_b[0], "R7 byte before NACK", 64'(rb), 64'(exp_b[0]));
        read_byte(1'b0, rb);
        chk(rb == 8'hFF, "R7 released after NACK", 64'(rb), 64'hFF);
        bus_stop();
        chk(sda_oe == 1'b0, "R10 released after stop", 64'(sda_oe), 64'(0));

        // R9 start in mid-byte: restart writes byte 0 again
        bus_start();
        write_byte(8'hD2, a);
        write_byte(8'h00, a);
        write_byte(8'h00, a);
        write_byte(8'h11, a);
        for (int i = 0; i < 4; i++) send_bit(i[0], s);
        bus_start();
        write_byte(8'hD2, a);
        write_byte(8'h00, a);
        write_byte(8'h00, a);
        write_byte(8'h22, a);
        chk(a == 1'b1, "R9 restarted frame acked", 64'(a), 64'(1));
        bus_stop();
        exp_b[0] = 8'h22;
        check_regs("R9 mid-byte start restarts at byte 0");

        // R9 stop in mid-byte: partial byte not stored
        bus_start();
        write_byte(8'hD2, a);
        write_byte(8'h00, a);
        write_byte(8'h00, a);
        for (int i = 0; i < 5; i++) send_bit(1'b0, s);
        bus_stop();
        check_regs("R9 mid-byte stop drops partial byte");

        chk(hold_viol == 0, "R10 no SDA change while SCL high", 64'(hold_viol), 64'(0));
        finish_run();
    end

endmodule